// File: doc/BRIEF.md
# Bit-Parallel Lookup-Table Decimating FIR Filter

This block forms one branch of a two-band analysis filter bank. It takes signed samples, runs them through a fixed-coefficient FIR filter, and keeps every second filtered result. The filter has no multipliers. Every bit position of the samples in the tap line forms an address into its own table of coefficient subset sums. All of those table outputs are weighted by their bit position and summed together in one cycle. Because of this, one sample can be accepted every clock, whatever the tap count.

Each time a filtered result is ready, the filter raises an internal completion strobe. That strobe advances a one-bit decimation phase. The phase decides whether the parallel-load output register captures the result or lets it go. A clear input zeroes the output register. The full-precision sum is `DATA_W + COEF_W + clog2(TAPS)` bits wide, so no rounding happens inside the filter. Any narrowing to the output width is chosen by explicit parameters (`OUT_SHIFT`, `OUT_W`).

Top module: `pda_decim_fir`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 0. Reset also empties the tap line to all-zero samples.
- R2: Samples and coefficients are two's complement, and the bit `DATA_W-1` of a sample has weight -2^(DATA_W-1). Each retained result equals sum over k of `COEFS[k] * x[n-k]`. Here tap k = 0 is the newest sample, and samples before reset count as zero.
- R3: A sample is taken on a rising edge where `in_valid` is 1. If the result for that sample is retained, it appears on `out_data`, with `out_valid` high, right after the next rising edge.
- R4: Decimation by two counts accepted samples from reset. The results for the 1st, 3rd, 5th, ... samples are retained. The results for the 2nd, 4th, ... samples are discarded and never appear.
- R5: `out_valid` is a single-cycle pulse and is never high on two consecutive cycles.
- R6: `out_data` keeps its value in every cycle where `out_valid` is 0, unless `clr` was sampled high on the edge before.
- R7: `clr` sampled high zeroes `out_data` on that edge and overrides a load due on the same edge. That result is lost, with `out_valid` left low. The decimation phase still advances.
- R8: Cycles with `in_valid` low neither shift the tap line nor advance the decimation phase, so idle gaps do not change the results.
- R9: A new sample may be accepted on every clock cycle, independent of `TAPS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zeroes the output register |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Two's complement input sample |
| out_valid | output | 1 | One-cycle strobe for a retained result |
| out_data | output | OUT_W | Retained filter result, two's complement |

## Verification
The bench sends single-sample impulses at both decimation phases. A mistake in tap order, in the table indexing or in the phase polarity then shows up as the wrong coefficient or as a result in the wrong slot. Impulses and runs at the most negative value test the sign handling of the top bit slice. A design that adds that slice instead of subtracting it gives large positive errors. Back-to-back random streams and streams with gaps test the every-cycle throughput and the rule that idle cycles do not shift the tap line. A clear that lands on the same edge as a load tests the priority and the phase advance. A design that lets the load win, or that stalls the phase, is seen at the ports as a stray pulse or as a shifted retention pattern.

// File: rtl/pda_decim_fir.sv
module pda_decim_fir #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 4,
  parameter int COEF_W = 8,
  parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{8'sd13, 8'sd64, 8'sd91, -8'sd27},
  parameter int OUT_SHIFT = 0,
  parameter int OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  localparam int SUM_W   = COEF_W + $clog2(TAPS);
  localparam int FULL_W  = DATA_W + SUM_W;
  localparam int ENTRIES = 1 << TAPS;

  function automatic logic signed [SUM_W-1:0] subset_sum(int unsigned sel);
    logic signed [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      if (sel[k]) acc = acc + SUM_W'(COEFS[k]);
    return acc;
  endfunction

  logic [DATA_W-1:0]       line_q [TAPS];
  logic signed [SUM_W-1:0] slice_sum [DATA_W];
  logic signed [FULL_W-1:0] full_sum;
  logic done_q, phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) line_q[k] <= '0;
    end else if (in_valid) begin
      line_q[0] <= in_data;
      for (int k = 1; k < TAPS; k++) line_q[k] <= line_q[k-1];
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_slice
    logic [TAPS-1:0]         addr;
    logic signed [SUM_W-1:0] table_w [ENTRIES];
    for (genvar k = 0; k < TAPS; k++) begin : g_addr
      assign addr[k] = line_q[k][b];
    end
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign table_w[e] = subset_sum(e);
    end
    assign slice_sum[b] = table_w[addr];
  end

  always_comb begin
    logic signed [FULL_W-1:0] term;
    full_sum = '0;
    for (int b = 0; b < DATA_W; b++) begin
      term = FULL_W'(slice_sum[b]) <<< b;
      if (b == DATA_W - 1) full_sum = full_sum - term;
      else                 full_sum = full_sum + term;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      phase_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      done_q    <= in_valid;
      out_valid <= 1'b0;
      if (done_q) phase_q <= ~phase_q;
      if (clr) begin
        out_data <= '0;
      end else if (done_q && !phase_q) begin
        out_data  <= full_sum[OUT_SHIFT +: OUT_W];
        out_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pda_decim_fir_chk.sv
module pda_decim_fir_chk #(
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_data == '0));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(clr)) |-> $stable(out_data));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_data == '0 && !out_valid));
endmodule

bind pda_decim_fir pda_decim_fir_chk #(.OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/pda_decim_fir_tb_top.sv
module pda_decim_fir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NT = 4;
  localparam int OW = 18;
  localparam int COEF_I [NT] = '{13, 64, 91, -27};

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [OW-1:0] out_data;

  pda_decim_fir dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int hist [NT];
  bit par = 1'b0;
  int exp_y [$];
  int exp_c [$];
  logic clr_seen = 1'b0, prev_valid = 1'b0;
  logic [OW-1:0] last_out = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    clr_seen <= clr;
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model_y();
    int s = 0;
    for (int k = 0; k < NT; k++) s += COEF_I[k] * hist[k];
    return s;
  endfunction

  task automatic send(int x, bit drop_load = 1'b0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    if (!par && !drop_load) begin
      exp_y.push_back(model_y());
      exp_c.push_back(cyc + 2);
    end
    par = ~par;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic drain(string req);
    idle(4);
    chk(exp_y.size() == 0, req, exp_y.size(), 0);
    exp_y.delete();
    exp_c.delete();
  endtask

  task automatic align_even();
    if (par) send(0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        chk(!prev_valid, "R5 consecutive valid", 1, 0);
        if (exp_y.size() == 0) begin
          chk(1'b0, "R4 unexpected output", $signed(out_data), 0);
        end else begin
          int y, c;
          y = exp_y.pop_front();
          c = exp_c.pop_front();
          chk($signed(out_data) == y, "R2 value", $signed(out_data), y);
          chk(cyc == c, "R3 timing", cyc, c);
        end
      end else if (!clr_seen) begin
        chk(out_data == last_out, "R6 hold", $signed(out_data), $signed(last_out));
      end
      prev_valid = out_valid;
      last_out   = out_data;
    end
  end

  task automatic t_reset();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_data == '0, "R1 data in reset", $signed(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_data == '0, "R1 data after reset", $signed(out_data), 0);
  endtask

  task automatic t_impulse();
    for (int k = 0; k < 6; k++) send(k == 0 ? 1 : 0);
    drain("R4 impulse even");
    align_even();
    for (int k = 0; k < 6; k++) send(k == 1 ? 1 : 0);
    drain("R4 impulse odd");
    for (int k = 0; k < 6; k++) send(k == 0 ? -128 : 0);
    drain("R2 negative impulse");
  endtask

  task automatic t_extremes();
    for (int k = 0; k < 8; k++) send(-128);
    for (int k = 0; k < 8; k++) send(127);
    for (int k = 0; k < 8; k++) send((k % 2) ? 127 : -128);
    drain("R2 extremes");
  endtask

  task automatic t_random_burst();
    for (int k = 0; k < 200; k++) send($signed(8'($urandom)));
    drain("R9 back-to-back");
  endtask

  task automatic t_gapped();
    for (int k = 0; k < 60; k++) begin
      send($signed(8'($urandom)));
      idle(1 + ($urandom % 4));
    end
    drain("R8 gapped");
  endtask

  task automatic t_clear();
    align_even();
    send(100);
    send(-50);
    idle(3);
    chk(out_data != '0, "R7 setup nonzero", $signed(out_data), 1);
    align_even();
    send(77, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(out_valid == 1'b0, "R7 load suppressed", out_valid, 0);
    chk(out_data == '0, "R7 cleared", $signed(out_data), 0);
    send(33);
    send(-21);
    drain("R7 phase advanced");
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_extremes();
    t_random_burst();
    t_gapped();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule